// File: doc/BRIEF.md
# Protected Key Store Controller

This block guards the two keys a configuration-decryption engine may use. A fixed manufacturer key is baked in as a parameter. A rewritable device key sits in a nonvolatile store, modelled here as registers that a device reset leaves alone. The device key can be written from two directions: the external configuration port, and a write-only port from user logic. Neither direction can ever read a key back. Key bits leave the block on one path only. That path goes to the decryption engine, and it is driven only while the engine requests it.

Each configuration load picks its key at the moment the load starts. The choice stays in force until the next load starts. A load marked as encrypted sets a lock flag that only a full device reset clears. While the lock is set, every configuration readback request and every partial-reconfiguration request is refused with an error instead of an acknowledge. User logic can read a fixed device identifier at any time.

Top module: `keyvault_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `enc_active`, `wr_collide`, `rb_ack`, `pr_ack` and `acc_err` are 0. The load key selection is the fixed key.
- R2: `eng_key` is all zeros in every cycle in which `eng_key_req` is 0, whatever writes or loads have happened.
- R3: A clock edge with `load_start`=1 captures the key selection: `load_use_dev`=0 selects the fixed key and 1 selects the device key. While `eng_key_req`=1, `eng_key` shows the selected key. The selection holds until the next `load_start`.
- R4: An edge with `ext_wr_en`=1 stores `ext_wr_key` as the device key. From the next cycle, the device key is what a device-key selection presents on `eng_key`.
- R5: An edge with `usr_wr_en`=1 and `ext_wr_en`=0 stores `usr_wr_key` as the device key. No output other than `eng_key` under request ever shows it.
- R6: If `ext_wr_en` and `usr_wr_en` are both 1 at the same edge, the external data is stored and the user data is dropped. `wr_collide` is 1 for exactly the following cycle. In every other case it is 0.
- R7: The device key changes only at an edge with a write strobe. It keeps its value across `rst_n`. Before the first write it holds the `DEV_KEY_INIT` parameter.
- R8: `enc_active` becomes 1 after an edge with `load_start`=1 and `load_encrypted`=1. It stays 1, even through later plain loads, until `rst_n` goes low.
- R9: A request on `rb_req` or `pr_req` is answered in the next cycle. If the lock is clear, the answer is the matching `rb_ack`/`pr_ack`=1 with `acc_err`=0. If `enc_active` is 1, or an encrypted load starts at the same edge, the answer is `acc_err`=1 with both acks 0.
- R10: `dev_id` equals the `DEVICE_ID` parameter at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full device reset, active low, asynchronous |
| ext_wr_en | input | 1 | External configuration port key write strobe |
| ext_wr_key | input | KEY_W | External write data |
| usr_wr_en | input | 1 | User-logic key write strobe (write-only path) |
| usr_wr_key | input | KEY_W | User-logic write data |
| wr_collide | output | 1 | Both write paths strobed at the previous edge |
| load_start | input | 1 | A configuration load begins |
| load_encrypted | input | 1 | The starting load is encrypted |
| load_use_dev | input | 1 | 0: fixed key, 1: device key for this load |
| enc_active | output | 1 | An encrypted configuration is active (lock) |
| eng_key_req | input | 1 | Decryption engine asks for key material |
| eng_key | output | KEY_W | Selected key while requested, zero otherwise |
| rb_req | input | 1 | Configuration readback request |
| pr_req | input | 1 | Partial reconfiguration request |
| rb_ack | output | 1 | Readback granted |
| pr_ack | output | 1 | Partial reconfiguration granted |
| acc_err | output | 1 | Request refused because of the lock |
| dev_id | output | ID_W | Device identifier |

## Verification
The key path is tested under several write patterns: an external write alone, a user write alone, and both at once. Each case distinguishes which data reached the store and whether the collision flag followed. Loads that alternate the key choice while the store is rewritten show that the selection is latched per load, not followed live. Readback and partial-reconfiguration requests are issued in three states: before any encrypted load, at the very edge of one, and after it. A reset in the middle of the sequence separates the lock, which must clear, from the device key, which must survive.

// File: rtl/kv_pkg.sv
package kv_pkg;

   typedef enum logic {
      KSEL_FIXED  = 1'b0,
      KSEL_DEVICE = 1'b1
   } key_sel_e;

   // request kinds guarded by the lock; index order is fixed
   localparam int unsigned ACC_READBACK = 0;
   localparam int unsigned ACC_PARTIAL  = 1;
   localparam int unsigned ACC_KINDS    = 2;

   typedef struct packed {
      logic [ACC_KINDS-1:0] ack;
      logic                 err;
   } acc_resp_t;

   function automatic key_sel_e to_sel(input logic use_dev);
      return use_dev ? KSEL_DEVICE : KSEL_FIXED;
   endfunction

endpackage

// File: rtl/kv_nv_store.sv
module kv_nv_store #(
   parameter int unsigned      KEY_W    = 256,
   parameter logic [KEY_W-1:0] INIT_KEY = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_we,
   input  logic [KEY_W-1:0] ext_d,
   input  logic             usr_we,
   input  logic [KEY_W-1:0] usr_d,
   output logic [KEY_W-1:0] key_o,
   output logic             collide_o
);

   // storage is outside the reset domain: it models a nonvolatile cell
   logic [KEY_W-1:0] key_q = INIT_KEY;
   logic             collide_q;
   logic             any_we;
   logic [KEY_W-1:0] wr_data;

   // external path has priority over the user path
   always_comb begin
      any_we  = ext_we | usr_we;
      wr_data = ext_we ? ext_d : usr_d;
   end

   always_ff @(posedge clk) begin
      if (any_we) key_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) collide_q <= 1'b0;
      else        collide_q <= ext_we & usr_we;
   end

   assign key_o     = key_q;
   assign collide_o = collide_q;

endmodule

// File: rtl/kv_load_ctrl.sv
module kv_load_ctrl
   import kv_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     encrypted,
   input  logic     use_dev,
   output key_sel_e sel_o,
   output logic     locked_o,
   output logic     lock_now_o
);

   key_sel_e sel_q;
   logic     lock_q;
   logic     enc_start;

   assign enc_start = start & encrypted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= KSEL_FIXED;
         lock_q <= 1'b0;
      end else begin
         if (start)     sel_q  <= to_sel(use_dev);
         if (enc_start) lock_q <= 1'b1;
      end
   end

   assign sel_o      = sel_q;
   assign locked_o   = lock_q;
   // lock seen by requests at this edge, including a load starting now
   assign lock_now_o = lock_q | enc_start;

endmodule

// File: rtl/kv_access_guard.sv
module kv_access_guard
   import kv_pkg::*;
#(
   parameter int unsigned KINDS = ACC_KINDS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KINDS-1:0] req,
   input  logic             lock,
   output logic [KINDS-1:0] ack_o,
   output logic             err_o
);

   logic [KINDS-1:0] ack_q;
   logic             err_q;

   for (genvar k = 0; k < KINDS; k++) begin : g_kind
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ack_q[k] <= 1'b0;
         else        ack_q[k] <= req[k] & ~lock;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= (|req) & lock;
   end

   assign ack_o = ack_q;
   assign err_o = err_q;

endmodule

// File: rtl/kv_key_gate.sv
module kv_key_gate
   import kv_pkg::*;
#(
   parameter int unsigned KEY_W  = 256,
   parameter int unsigned LANE_W = 32
) (
   input  logic             req,
   input  key_sel_e         sel,
   input  logic [KEY_W-1:0] fixed_key,
   input  logic [KEY_W-1:0] dev_key,
   output logic [KEY_W-1:0] key_o
);

   localparam int unsigned LANES = KEY_W / LANE_W;

   // each lane selects then gates, keeping fan-in per lane small
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] pick;
      always_comb begin
         pick = (sel == KSEL_DEVICE) ? dev_key[g*LANE_W +: LANE_W]
                                     : fixed_key[g*LANE_W +: LANE_W];
         key_o[g*LANE_W +: LANE_W] = req ? pick : '0;
      end
   end

endmodule

// File: rtl/keyvault_ctrl.sv
module keyvault_ctrl
   import kv_pkg::*;
#(
   parameter int unsigned      KEY_W        = 256,
   parameter int unsigned      ID_W         = 128,
   parameter int unsigned      LANE_W       = 32,
   parameter logic [KEY_W-1:0] FIXED_KEY    = {8{32'h5A3C_96E1}},
   parameter logic [KEY_W-1:0] DEV_KEY_INIT = '0,
   parameter logic [ID_W-1:0]  DEVICE_ID    = {4{32'h0D1C_E7A5}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_wr_en,
   input  logic [KEY_W-1:0] ext_wr_key,
   input  logic             usr_wr_en,
   input  logic [KEY_W-1:0] usr_wr_key,
   output logic             wr_collide,
   input  logic             load_start,
   input  logic             load_encrypted,
   input  logic             load_use_dev,
   output logic             enc_active,
   input  logic             eng_key_req,
   output logic [KEY_W-1:0] eng_key,
   input  logic             rb_req,
   input  logic             pr_req,
   output logic             rb_ack,
   output logic             pr_ack,
   output logic             acc_err,
   output logic [ID_W-1:0]  dev_id
);

   if (KEY_W == 0 || ID_W == 0) begin : g_bad_width
      $error("keyvault_ctrl: KEY_W and ID_W must be non-zero");
   end
   if (LANE_W == 0 || (KEY_W % LANE_W) != 0) begin : g_bad_lane
      $error("keyvault_ctrl: LANE_W must divide KEY_W");
   end

   logic [KEY_W-1:0]     nv_key;
   key_sel_e             sel;
   logic                 lock_now;
   logic [ACC_KINDS-1:0] acc_req;
   acc_resp_t            resp;

   kv_nv_store #(
      .KEY_W    (KEY_W),
      .INIT_KEY (DEV_KEY_INIT)
   ) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_we    (ext_wr_en),
      .ext_d     (ext_wr_key),
      .usr_we    (usr_wr_en),
      .usr_d     (usr_wr_key),
      .key_o     (nv_key),
      .collide_o (wr_collide)
   );

   kv_load_ctrl load_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (load_start),
      .encrypted  (load_encrypted),
      .use_dev    (load_use_dev),
      .sel_o      (sel),
      .locked_o   (enc_active),
      .lock_now_o (lock_now)
   );

   always_comb begin
      acc_req               = '0;
      acc_req[ACC_READBACK] = rb_req;
      acc_req[ACC_PARTIAL]  = pr_req;
   end

   kv_access_guard #(
      .KINDS (ACC_KINDS)
   ) guard_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (acc_req),
      .lock  (lock_now),
      .ack_o (resp.ack),
      .err_o (resp.err)
   );

   assign rb_ack  = resp.ack[ACC_READBACK];
   assign pr_ack  = resp.ack[ACC_PARTIAL];
   assign acc_err = resp.err;

   kv_key_gate #(
      .KEY_W  (KEY_W),
      .LANE_W (LANE_W)
   ) gate_i (
      .req       (eng_key_req),
      .sel       (sel),
      .fixed_key (FIXED_KEY),
      .dev_key   (nv_key),
      .key_o     (eng_key)
   );

   assign dev_id = DEVICE_ID;

endmodule

// File: rtl/kv_ctrl_chk.sv
module kv_ctrl_chk #(
   parameter int unsigned KEY_W = 256
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ext_wr_en,
   input logic [KEY_W-1:0] ext_wr_key,
   input logic             usr_wr_en,
   input logic [KEY_W-1:0] usr_wr_key,
   input logic             wr_collide,
   input logic             load_start,
   input logic             load_encrypted,
   input logic             enc_active,
   input logic             eng_key_req,
   input logic [KEY_W-1:0] eng_key,
   input logic             rb_req,
   input logic             pr_req,
   input logic             rb_ack,
   input logic             pr_ack,
   input logic             acc_err,
   input logic [KEY_W-1:0] nv_key
);

   // R2
   key_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_key_req |-> eng_key == '0);

   // R4
   ext_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr_en |=> nv_key == $past(ext_wr_key));

   // R5
   usr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_wr_en && !ext_wr_en) |=> nv_key == $past(usr_wr_key));

   // R7
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!usr_wr_en && !ext_wr_en) |=> $stable(nv_key));

   // R6
   collide_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr_en && usr_wr_en) |=> wr_collide);

   // R6
   collide_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_wr_en && usr_wr_en) |=> !wr_collide);

   // R8
   lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_start && load_encrypted) |=> enc_active);

   // R8
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_active |=> enc_active);

   // R9
   locked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rb_req || pr_req) && enc_active) |=> (acc_err && !rb_ack && !pr_ack));

   // R9
   open_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_req && !enc_active && !(load_start && load_encrypted)) |=> (rb_ack && !acc_err));

   // R9
   ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_err && (rb_ack || pr_ack)));

endmodule

bind keyvault_ctrl kv_ctrl_chk #(.KEY_W(KEY_W)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .ext_wr_en      (ext_wr_en),
   .ext_wr_key     (ext_wr_key),
   .usr_wr_en      (usr_wr_en),
   .usr_wr_key     (usr_wr_key),
   .wr_collide     (wr_collide),
   .load_start     (load_start),
   .load_encrypted (load_encrypted),
   .enc_active     (enc_active),
   .eng_key_req    (eng_key_req),
   .eng_key        (eng_key),
   .rb_req         (rb_req),
   .pr_req         (pr_req),
   .rb_ack         (rb_ack),
   .pr_ack         (pr_ack),
   .acc_err        (acc_err),
   .nv_key         (nv_key)
);

// File: tb/keyvault_ctrl_tb_top.sv
module keyvault_ctrl_tb_top;

   localparam int unsigned KW = 256;
   localparam int unsigned IW = 128;
   localparam logic [KW-1:0] FIX  = {8{32'hC0FF_EE11}};
   localparam logic [KW-1:0] INIT = {8{32'h1234_5678}};
   localparam logic [IW-1:0] ID   = {4{32'hFACE_0042}};
   localparam logic [KW-1:0] K1 = {8{32'hA1A1_0001}};
   localparam logic [KW-1:0] K2 = {8{32'hB2B2_0002}};
   localparam logic [KW-1:0] K3 = {8{32'hC3C3_0003}};
   localparam logic [KW-1:0] K4 = {8{32'hD4D4_0004}};
   localparam logic [KW-1:0] K5 = {8{32'hE5E5_0005}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ext_wr_en = 1'b0, usr_wr_en = 1'b0;
   logic [KW-1:0] ext_wr_key = '0, usr_wr_key = '0;
   logic          load_start = 1'b0, load_encrypted = 1'b0, load_use_dev = 1'b0;
   logic          eng_key_req = 1'b0, rb_req = 1'b0, pr_req = 1'b0;
   logic          wr_collide, enc_active, rb_ack, pr_ack, acc_err;
   logic [KW-1:0] eng_key;
   logic [IW-1:0] dev_id;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #10ns clk = ~clk;

   keyvault_ctrl #(
      .KEY_W(KW), .ID_W(IW), .FIXED_KEY(FIX), .DEV_KEY_INIT(INIT), .DEVICE_ID(ID)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ext_wr_en(ext_wr_en), .ext_wr_key(ext_wr_key),
      .usr_wr_en(usr_wr_en), .usr_wr_key(usr_wr_key),
      .wr_collide(wr_collide),
      .load_start(load_start), .load_encrypted(load_encrypted), .load_use_dev(load_use_dev),
      .enc_active(enc_active),
      .eng_key_req(eng_key_req), .eng_key(eng_key),
      .rb_req(rb_req), .pr_req(pr_req),
      .rb_ack(rb_ack), .pr_ack(pr_ack), .acc_err(acc_err),
      .dev_id(dev_id)
   );

   task automatic chk(input string tag, input logic [KW-1:0] got, input logic [KW-1:0] exp);
      nvec++;
      if (got !== exp) begin
         nbad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic peek_key(input string tag, input logic [KW-1:0] exp);
      eng_key_req = 1'b1;
      #1ns;
      chk(tag, eng_key, exp);
      eng_key_req = 1'b0;
      #1ns;
      chk("R2 key gated off after request", eng_key, '0);
   endtask

   task automatic do_load(input logic enc, input logic dev);
      load_start = 1'b1; load_encrypted = enc; load_use_dev = dev;
      step();
      load_start = 1'b0; load_encrypted = 1'b0; load_use_dev = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      chk("R10 id during reset", KW'(dev_id), KW'(ID));
      chk("R1 lock in reset", KW'(enc_active), '0);
      rst_n = 1'b1;
      step();
      chk("R1 collide after reset", KW'(wr_collide), '0);
      chk("R1 acks after reset", KW'({rb_ack, pr_ack, acc_err}), '0);
      chk("R1 lock after reset", KW'(enc_active), '0);
      peek_key("R1 default selection fixed", FIX);
   endtask

   task automatic t_init_key();
      do_load(1'b0, 1'b1);
      peek_key("R7 store holds init value", INIT);
   endtask

   task automatic t_ext_write();
      ext_wr_en = 1'b1; ext_wr_key = K1;
      step();
      ext_wr_en = 1'b0;
      chk("R6 no collide on single write", KW'(wr_collide), '0);
      peek_key("R4 external write", K1);
   endtask

   task automatic t_usr_write();
      usr_wr_en = 1'b1; usr_wr_key = K2;
      step();
      usr_wr_en = 1'b0;
      #1ns;
      chk("R5 no key on idle output", eng_key, '0);
      chk("R10 id unaffected by write", KW'(dev_id), KW'(ID));
      peek_key("R5 user write", K2);
   endtask

   task automatic t_collide();
      ext_wr_en = 1'b1; ext_wr_key = K3;
      usr_wr_en = 1'b1; usr_wr_key = K4;
      step();
      ext_wr_en = 1'b0; usr_wr_en = 1'b0;
      chk("R6 collide flag raised", KW'(wr_collide), KW'(1));
      peek_key("R6 external wins", K3);
      step();
      chk("R6 collide flag one cycle", KW'(wr_collide), '0);
   endtask

   task automatic t_sel_per_load();
      do_load(1'b0, 1'b0);
      peek_key("R3 fixed selected", FIX);
      ext_wr_en = 1'b1; ext_wr_key = K5;
      step();
      ext_wr_en = 1'b0;
      peek_key("R3 write does not change selection", FIX);
      do_load(1'b0, 1'b1);
      peek_key("R3 device selected on next load", K5);
   endtask

   task automatic t_access_open();
      rb_req = 1'b1;
      step();
      rb_req = 1'b0;
      chk("R9 readback granted when open", KW'({rb_ack, pr_ack, acc_err}), KW'(3'b100));
      pr_req = 1'b1;
      step();
      pr_req = 1'b0;
      chk("R9 partial granted when open", KW'({rb_ack, pr_ack, acc_err}), KW'(3'b010));
      step();
      chk("R9 response clears", KW'({rb_ack, pr_ack, acc_err}), '0);
   endtask

   task automatic t_enc_lock();
      rb_req = 1'b1;
      do_load(1'b1, 1'b1);
      rb_req = 1'b0;
      chk("R9 refused at encrypted load edge", KW'({rb_ack, pr_ack, acc_err}), KW'(3'b001));
      chk("R8 lock set", KW'(enc_active), KW'(1));
      do_load(1'b0, 1'b0);
      chk("R8 plain load keeps lock", KW'(enc_active), KW'(1));
      pr_req = 1'b1;
      step();
      pr_req = 1'b0;
      chk("R9 partial refused while locked", KW'({rb_ack, pr_ack, acc_err}), KW'(3'b001));
      peek_key("R3 plain load chose fixed", FIX);
   endtask

   task automatic t_reset_persist();
      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
      step();
      chk("R8 reset clears lock", KW'(enc_active), '0);
      peek_key("R1 selection back to fixed", FIX);
      do_load(1'b0, 1'b1);
      peek_key("R7 device key survives reset", K5);
      rb_req = 1'b1;
      step();
      rb_req = 1'b0;
      chk("R9 readback granted after reset", KW'({rb_ack, acc_err}), KW'(2'b10));
   endtask

   initial begin
      step();
      t_reset();
      t_init_key();
      t_ext_write();
      t_usr_write();
      t_collide();
      t_sel_per_load();
      t_access_open();
      t_enc_lock();
      t_reset_persist();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule